// File: doc/BRIEF.md
# Serial Bus Byte Shifter with Busy Handshake

This block moves one byte at a time over a two-wire bus made of a serial clock and a single open-drain data line. A CPU starts each byte by writing the data port while the enable input is high. When the block is bus master it generates the clock itself. As a slave it follows the clock that another device drives. Bits leave most-significant first, change after a falling clock edge and are captured on a rising one. The captured byte can be read back once the byte ends, and an interrupt flag is raised at that point.

A master write is held back while the slave keeps the data line low (busy). The held byte goes out as soon as the line reads high again. A slave can hold the line low as a busy signal; a clear command releases it only at the next falling clock edge. In wake-up mode the block never drives data. It raises its flag only when the first byte seen after a bus-release event equals its own address.

Top module: `sbus_shift_unit`

## Requirements
- R1: After reset, `irq` is 0, `sda_low` is 0, `sck_out` is 1 and `rd_data` is 00h.
- R2: A write while `enable` is 0 starts nothing, and raising `enable` afterwards does not start that earlier byte (no clock edges, `irq` stays 0).
- R3: A master write with `enable` high, the clock line high and the data line high produces exactly 8 falling edges on `sck_out`. The clock then rests high and `irq` becomes 1.
- R4: The written byte leaves most-significant bit first, with `sda_low` = 1 meaning a 0 bit. `rd_data` holds the 8 line levels sampled on rising clock edges, with the first sample in bit 7, so it is the wired-AND of both senders.
- R5: A master write while the data line reads low is kept. No clock runs until the line reads high, and then the kept byte is sent in full.
- R6: While `wake_mode` is 1, the shifted data never pulls the line low, whatever byte was written.
- R7: With `wake_mode` 1, `irq` rises at the end of a byte only if a `bus_release` pulse came before that byte and the byte equals `own_addr`. Every completed byte consumes the release. With `wake_mode` 0, every completed byte sets `irq`.
- R8: After `busy_set`, `sda_low` stays 1. After `busy_clr`, it stays 1 until the first falling edge of `sck_in` that follows, and then returns to 0.
- R9: Changing `wake_mode` to 1 while busy is driven leaves `sda_low` at 1.
- R10: `irq` stays 1 until an `irq_clr` pulse. A write made during a byte in progress is ignored and does not alter the byte being received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Interface enable |
| is_master | input | 1 | 1: block generates the serial clock |
| wake_mode | input | 1 | Address-match wake-up mode |
| wr_en | input | 1 | Data port write strobe |
| wr_data | input | 8 | Byte to send |
| rd_data | output | 8 | Shift register contents (received byte) |
| irq_clr | input | 1 | Clears the interrupt flag |
| irq | output | 1 | Transfer-complete / address-match flag |
| bus_release | input | 1 | Pulse: bus release condition seen |
| busy_set | input | 1 | Pulse: start driving busy |
| busy_clr | input | 1 | Pulse: request busy release |
| own_addr | input | 8 | Local slave address |
| sck_in | input | 1 | Serial clock line level |
| sck_out | output | 1 | Generated serial clock (master) |
| sda_in | input | 1 | Data line level (wired-AND) |
| sda_low | output | 1 | Open-drain pull-low enable |

## Verification
The assertions assume that `sck_in` is the level of the real clock line. In master mode this means it follows `sck_out`. They also assume that each clock phase outside the block lasts several system clocks, so every edge is seen once. The bench feeds `sck_out` back as `sck_in` whenever the block is master. When the bench acts as master, each clock phase it drives lasts four system cycles. The bench sends `busy_clr` and `irq_clr` only as single-cycle pulses while the clock is idle.

// File: rtl/sbsu_pkg.sv
package sbsu_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned CNT_W  = $clog2(BYTE_W + 1);

    typedef struct packed {
        logic              active;
        logic              pend;
        logic [BYTE_W-1:0] sr;
        logic [CNT_W-1:0]  bits;
        logic              out;
        logic              irq;
        logic              rel;
        logic              busy;
        logic              clr_pend;
    } sbsu_state_t;
endpackage

// File: rtl/sbsu_edge.sv
module sbsu_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic rise,
    output logic fall
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = sig_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= prev_d;
    end

    assign rise = sig_in & ~prev_q;
    assign fall = ~sig_in & prev_q;
endmodule

// File: rtl/sbsu_clkgen.sv
module sbsu_clkgen #(
    parameter int unsigned HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sck
);
    localparam int unsigned DIV_W = (HALF > 1) ? $clog2(HALF) : 1;

    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic             gen_d, gen_q;

    always_comb begin
        cnt_d = cnt_q;
        gen_d = gen_q;
        if (!run) begin
            cnt_d = '0;
            gen_d = 1'b1;
        end else if (cnt_q == DIV_W'(HALF - 1)) begin
            cnt_d = '0;
            gen_d = ~gen_q;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            gen_q <= 1'b1;
        end else begin
            cnt_q <= cnt_d;
            gen_q <= gen_d;
        end
    end

    assign sck = gen_q | ~run;
endmodule

// File: rtl/sbus_shift_unit.sv
module sbus_shift_unit
    import sbsu_pkg::*;
#(
    parameter int unsigned SCK_HALF = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              is_master,
    input  logic              wake_mode,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              irq_clr,
    output logic              irq,
    input  logic              bus_release,
    input  logic              busy_set,
    input  logic              busy_clr,
    input  logic [BYTE_W-1:0] own_addr,
    input  logic              sck_in,
    output logic              sck_out,
    input  logic              sda_in,
    output logic              sda_low
);
    sbsu_state_t st_d, st_q;

    logic              sck_rise;
    logic              sck_fall;
    logic              gen_sck;
    logic              xfer_on;
    logic              busy_drv;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shifted;
    logic              last_bit;

    sbsu_edge i_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig_in(sck_in),
        .rise  (sck_rise),
        .fall  (sck_fall)
    );

    sbsu_clkgen #(.HALF(SCK_HALF)) i_clkgen (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (st_q.active & is_master),
        .sck  (gen_sck)
    );

    assign shifted  = {st_q.sr[BYTE_W-2:0], sda_in};
    assign last_bit = st_q.active && sck_rise && (st_q.bits == CNT_W'(BYTE_W - 1));

    always_comb begin
        st_d = st_q;

        // start / hold of a written byte
        if (!enable) st_d.pend = 1'b0;
        if (wr_en && !st_q.active) begin
            st_d.sr = wr_data;
            if (enable && sck_in) begin
                if (is_master && !sda_in) begin
                    st_d.pend = 1'b1;
                end else begin
                    st_d.active = 1'b1;
                    st_d.pend   = 1'b0;
                    st_d.bits   = '0;
                    st_d.out    = wr_data[BYTE_W-1];
                end
            end
        end else if (st_q.pend && enable && sda_in && sck_in && !st_q.active) begin
            st_d.active = 1'b1;
            st_d.pend   = 1'b0;
            st_d.bits   = '0;
            st_d.out    = st_q.sr[BYTE_W-1];
        end

        // shifting
        if (st_q.active) begin
            if (sck_rise) begin
                st_d.sr   = shifted;
                st_d.bits = st_q.bits + 1'b1;
            end
            if (sck_fall) st_d.out = st_q.sr[BYTE_W-1];
            if (last_bit) begin
                st_d.active = 1'b0;
                st_d.out    = 1'b1;
            end
        end

        // interrupt flag and release tracking
        if (irq_clr) st_d.irq = 1'b0;
        if (last_bit) begin
            if (!wake_mode || (st_q.rel && shifted == own_addr)) st_d.irq = 1'b1;
            st_d.rel = 1'b0;
        end
        if (bus_release) st_d.rel = 1'b1;

        // busy handshake
        if (busy_set) st_d.busy = 1'b1;
        if (busy_clr && st_q.busy) st_d.clr_pend = 1'b1;
        if (st_q.clr_pend && sck_fall) begin
            st_d.busy     = 1'b0;
            st_d.clr_pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.out      <= 1'b1;
        end else begin
            st_q          <= st_d;
        end
    end

    assign xfer_on  = st_q.active;
    assign busy_drv = st_q.busy;
    assign bit_cnt  = st_q.bits;
    assign rd_data  = st_q.sr;
    assign irq      = st_q.irq;
    assign sck_out  = is_master ? gen_sck : 1'b1;
    assign sda_low  = st_q.busy | (st_q.active & ~wake_mode & ~st_q.out);
endmodule

// File: rtl/sbsu_chk.sv
module sbsu_chk
    import sbsu_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             is_master,
    input logic             wake_mode,
    input logic             irq,
    input logic             irq_clr,
    input logic             sck_out,
    input logic             sda_low,
    input logic             active,
    input logic             busy,
    input logic             fall,
    input logic [CNT_W-1:0] bits
);
    // R10
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !irq_clr |=> irq);

    // R2
    start_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(enable));

    // R8
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(fall));

    // R3
    bit_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bits <= CNT_W'(BYTE_W));

    // R3
    sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> sck_out);

    // R6
    wake_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_mode && !busy |-> !sda_low);

    // R9
    busy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !fall |=> busy);

    // R3
    master_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_master |-> sck_out);
endmodule

bind sbus_shift_unit sbsu_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .is_master(is_master),
    .wake_mode(wake_mode),
    .irq      (irq),
    .irq_clr  (irq_clr),
    .sck_out  (sck_out),
    .sda_low  (sda_low),
    .active   (xfer_on),
    .busy     (busy_drv),
    .fall     (sck_fall),
    .bits     (bit_cnt)
);

// File: tb/test_sbus_shift_unit.sv
module test_sbus_shift_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0, is_master = 1'b1, wake_mode = 1'b0;
    logic       wr_en = 1'b0, irq_clr = 1'b0, bus_release = 1'b0;
    logic       busy_set = 1'b0, busy_clr = 1'b0;
    logic [7:0] wr_data = 8'h00, own_addr = 8'h5A;
    logic [7:0] rd_data;
    logic       irq, sck_out, sda_low;
    logic       bench_sck = 1'b1, bench_low = 1'b0;
    logic       sck_line, sda_line;
    int         total = 0, bad = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    assign sck_line = is_master ? sck_out : bench_sck;
    assign sda_line = ~(sda_low | bench_low);

    sbus_shift_unit i_sbus_shift_unit (
        .clk(clk), .rst_n(rst_n), .enable(enable), .is_master(is_master),
        .wake_mode(wake_mode), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .irq_clr(irq_clr), .irq(irq), .bus_release(bus_release),
        .busy_set(busy_set), .busy_clr(busy_clr), .own_addr(own_addr),
        .sck_in(sck_line), .sck_out(sck_out), .sda_in(sda_line), .sda_low(sda_low)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_write(input logic [7:0] d);
        @(negedge clk); wr_data = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic pulse_irq_clr();
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
    endtask

    // bench acts as slave; counts clock falls and records the block's bits
    task automatic master_run(input logic [7:0] send, output int falls, output logic [7:0] got);
        logic prev = sck_out;
        falls = 0; got = 8'h00;
        for (int n = 0; n < 600 && !irq; n++) begin
            @(negedge clk);
            if (prev && !sck_out) begin
                if (falls < 8) bench_low = ~send[7 - falls];
                falls++;
            end
            if (!prev && sck_out) got = {got[6:0], ~sda_low};
            prev = sck_out;
        end
        repeat (20) begin
            @(negedge clk);
            if (prev && !sck_out) falls++;
            prev = sck_out;
        end
        bench_low = 1'b0;
    endtask

    // bench acts as master clock source
    task automatic slave_byte(input logic [7:0] send, output logic [7:0] got, output bit any_low);
        got = 8'h00; any_low = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); bench_sck = 1'b0; bench_low = ~send[7 - i];
            repeat (4) begin @(negedge clk); any_low |= sda_low; end
            got = {got[6:0], ~sda_low};
            bench_sck = 1'b1;
            repeat (4) begin @(negedge clk); any_low |= sda_low; end
        end
        bench_low = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(irq == 1'b0, "R1 irq", irq, 0);
        chk(sda_low == 1'b0, "R1 sda_low", sda_low, 0);
        chk(sck_out == 1'b1, "R1 sck_out", sck_out, 1);
        chk(rd_data == 8'h00, "R1 rd_data", rd_data, 0);
    endtask

    task automatic t_late_enable();
        int falls = 0;
        logic prev = 1'b1;
        is_master = 1'b1; enable = 1'b0;
        pulse_write(8'h3C);
        @(negedge clk); enable = 1'b1;
        repeat (60) begin
            @(negedge clk);
            if (prev && !sck_out) falls++;
            prev = sck_out;
        end
        chk(falls == 0, "R2 clock edges", falls, 0);
        chk(irq == 1'b0, "R2 irq", irq, 0);
    endtask

    task automatic t_master_basic();
        int falls; logic [7:0] got;
        pulse_write(8'hA5);
        master_run(8'hFF, falls, got);
        chk(falls == 8, "R3 falling edges", falls, 8);
        chk(irq == 1'b1, "R3 irq", irq, 1);
        chk(sck_out == 1'b1, "R3 clock rests high", sck_out, 1);
        chk(got == 8'hA5, "R4 bits on line", got, 8'hA5);
        chk(rd_data == 8'hA5, "R4 rd_data own byte", rd_data, 8'hA5);
        pulse_irq_clr();
        chk(irq == 1'b0, "R10 irq cleared", irq, 0);
    endtask

    task automatic t_master_receive();
        int falls; logic [7:0] got;
        pulse_write(8'hFF);
        master_run(8'h3C, falls, got);
        chk(rd_data == 8'h3C, "R4 received byte", rd_data, 8'h3C);
        chk(falls == 8, "R3 falling edges rx", falls, 8);
        repeat (20) @(negedge clk);
        chk(irq == 1'b1, "R10 irq held", irq, 1);
        pulse_irq_clr();
    endtask

    task automatic t_busy_hold();
        int falls; logic [7:0] got;
        logic seen_low = 1'b0;
        @(negedge clk); bench_low = 1'b1;
        pulse_write(8'h69);
        repeat (40) begin @(negedge clk); seen_low |= ~sck_out; end
        chk(seen_low == 1'b0, "R5 no clock while busy", seen_low, 0);
        @(negedge clk); bench_low = 1'b0;
        master_run(8'hFF, falls, got);
        chk(falls == 8, "R5 held byte sent", falls, 8);
        chk(got == 8'h69, "R5 held byte value", got, 8'h69);
        pulse_irq_clr();
    endtask

    task automatic t_slave_plain();
        logic [7:0] got; bit any_low;
        is_master = 1'b0; wake_mode = 1'b0;
        pulse_write(8'h96);
        slave_byte(8'hC3, got, any_low);
        chk(got == 8'h96, "R4 slave output order", got, 8'h96);
        chk(rd_data == 8'h82, "R4 wired-AND capture", rd_data, 8'h82);
        chk(irq == 1'b1, "R7 irq without wake", irq, 1);
        pulse_irq_clr();
    endtask

    task automatic t_ignored_write();
        logic [7:0] got; bit any_low;
        pulse_write(8'hFF);
        // byte in progress: a write mid-way must be ignored
        fork
            slave_byte(8'h5C, got, any_low);
            begin repeat (30) @(negedge clk); wr_data = 8'h00; wr_en = 1'b1;
                  @(negedge clk); wr_en = 1'b0; end
        join
        chk(rd_data == 8'h5C, "R10 write ignored in flight", rd_data, 8'h5C);
        pulse_irq_clr();
    endtask

    task automatic t_wake();
        logic [7:0] got; bit any_low;
        wake_mode = 1'b1;
        @(negedge clk); bus_release = 1'b1;
        @(negedge clk); bus_release = 1'b0;
        pulse_write(8'h00);
        slave_byte(8'h5A, got, any_low);
        chk(any_low == 1'b0, "R6 no drive in wake", any_low, 0);
        chk(irq == 1'b1, "R7 match after release", irq, 1);
        chk(rd_data == 8'h5A, "R7 address captured", rd_data, 8'h5A);
        pulse_irq_clr();
        pulse_write(8'h00);
        slave_byte(8'h5A, got, any_low);
        chk(irq == 1'b0, "R7 release consumed", irq, 0);
        @(negedge clk); bus_release = 1'b1;
        @(negedge clk); bus_release = 1'b0;
        pulse_write(8'h00);
        slave_byte(8'h33, got, any_low);
        chk(irq == 1'b0, "R7 address mismatch", irq, 0);
        wake_mode = 1'b0;
    endtask

    task automatic t_busy_release();
        is_master = 1'b0; wake_mode = 1'b0; bench_sck = 1'b1;
        @(negedge clk); busy_set = 1'b1;
        @(negedge clk); busy_set = 1'b0;
        chk(sda_low == 1'b1, "R8 busy driven", sda_low, 1);
        @(negedge clk); wake_mode = 1'b1;
        repeat (3) @(negedge clk);
        chk(sda_low == 1'b1, "R9 wake keeps busy", sda_low, 1);
        @(negedge clk); busy_clr = 1'b1;
        @(negedge clk); busy_clr = 1'b0;
        repeat (10) @(negedge clk);
        chk(sda_low == 1'b1, "R8 busy until clock falls", sda_low, 1);
        bench_sck = 1'b0;
        @(negedge clk);
        chk(sda_low == 1'b0, "R8 busy freed at fall", sda_low, 0);
        bench_sck = 1'b1;
        @(negedge clk); wake_mode = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_late_enable();
        t_master_basic();
        t_master_receive();
        t_busy_hold();
        t_slave_plain();
        t_ignored_write();
        t_wake();
        t_busy_release();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule